// File: doc/BRIEF.md
# Truncation Error-Tolerant Approximate Adder

This block adds two unsigned operands while allowing a bounded error in the low-order bits. In return, the long carry chain is cut short. The operand word is split at a compile-time boundary. The upper section is an exact ripple-carry adder whose carry-in is held at zero. The lower section has no carry chain at all.

In the lower section, a control chain scans from its top bit down toward bit 0 and looks for the first position where both operand bits are 1. Above that position, each sum bit is the plain XOR of the operand bits. At that position and every position below it, the sum bit is forced to 1. The result is one bit wider than the operands, and its top bit is the carry-out of the upper chain.

The block is purely combinational. It suits signal-processing datapaths that can absorb a small error in the low-order bits.

Top module: `approx_trunc_adder`

## Requirements
- R1: Bits sum_o[OP_W:INACC_W] equal the exact sum of a_i[OP_W-1:INACC_W] and b_i[OP_W-1:INACC_W], computed with a zero carry-in. Bit OP_W is the carry-out of that upper addition.
- R2: In the lower section, every sum bit above the highest position where a_i and b_i are both 1 equals a_i XOR b_i at that bit.
- R3: In the lower section, the sum bit at the highest position where a_i and b_i are both 1, and every sum bit below it, are 1.
- R4: When no lower position has both operand bits set, the lower sum bits equal a_i[INACC_W-1:0] + b_i[INACC_W-1:0] exactly.
- R5: sum_o never exceeds the exact sum a_i + b_i.
- R6: With OP_W=16 and INACC_W=8, the inputs a_i=45978 and b_i=26899 give sum_o=72863; the exact sum is 72877.
- R7: The lower operand bits never change sum_o[OP_W:INACC_W]. Even when both lower halves are all ones, no carry enters the upper section.
- R8: The exact sum minus sum_o is always less than 2^(INACC_W+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | OP_W | First unsigned operand |
| b_i | input | OP_W | Second unsigned operand |
| sum_o | output | OP_W+1 | Approximate sum, with the upper-section carry-out in the top bit |

## Verification
Every time the inputs change, the assertions check four things: that the upper field matches an exact addition of the upper halves (R1); that a lower section free of double-one positions yields an exact lower sum (R4); that the result never overshoots the exact sum (R5); and that the shortfall stays within its bound (R8). Only the bench scenarios can show the exact per-bit saturation pattern against a reference scan (R2, R3), the worked example (R6), and the fact that lower inputs such as all-ones halves leave the upper field untouched (R7). The lower halves are swept exhaustively while the upper halves are randomized.

// File: rtl/approx_add_pkg.sv
package approx_add_pkg;
  localparam int unsigned DEF_OP_W    = 16;
  localparam int unsigned DEF_INACC_W = 8;

  typedef struct packed {
    logic cout;
    logic sum;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
    fa_out_t r;
    r.sum  = a ^ b ^ cin;
    r.cout = (a & b) | (cin & (a ^ b));
    return r;
  endfunction
endpackage

// File: rtl/exact_rca.sv
module exact_rca
  import approx_add_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    fa_out_t fa;
    assign fa          = full_add(a_i[i], b_i[i], carry[i]);
    assign sum_o[i]    = fa.sum;
    assign carry[i+1]  = fa.cout;
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] ctl_o
);
  // Top-down chain: once a double-one is seen, every lower bit is controlled.
  assign ctl_o[W-1] = a_i[W-1] & b_i[W-1];

  for (genvar i = W - 1; i > 0; i--) begin : g_chain
    assign ctl_o[i-1] = ctl_o[i] | (a_i[i-1] & b_i[i-1]);
  end
endmodule

// File: rtl/carry_free_sum.sv
module carry_free_sum #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] ctl_i,
  output logic [W-1:0] sum_o
);
  // Per-bit XOR that saturates to 1 under control.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = ctl_i[i] | (a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/approx_trunc_adder.sv
module approx_trunc_adder
  import approx_add_pkg::*;
#(
  parameter int unsigned OP_W    = DEF_OP_W,
  parameter int unsigned INACC_W = DEF_INACC_W
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [OP_W:0]   sum_o
);
  localparam int unsigned ACC_W = OP_W - INACC_W;

  logic [INACC_W-1:0] ctl;
  logic [INACC_W-1:0] lo_sum;
  logic [ACC_W-1:0]   hi_sum;
  logic               hi_cout;

  sat_ctrl #(.W(INACC_W)) u_ctrl (
    .a_i   (a_i[INACC_W-1:0]),
    .b_i   (b_i[INACC_W-1:0]),
    .ctl_o (ctl)
  );

  carry_free_sum #(.W(INACC_W)) u_lo (
    .a_i   (a_i[INACC_W-1:0]),
    .b_i   (b_i[INACC_W-1:0]),
    .ctl_i (ctl),
    .sum_o (lo_sum)
  );

  exact_rca #(.W(ACC_W)) u_hi (
    .a_i    (a_i[OP_W-1:INACC_W]),
    .b_i    (b_i[OP_W-1:INACC_W]),
    .sum_o  (hi_sum),
    .cout_o (hi_cout)
  );

  assign sum_o = {hi_cout, hi_sum, lo_sum};
endmodule

// File: rtl/approx_trunc_adder_chk.sv
module approx_trunc_adder_chk #(
  parameter int unsigned OP_W    = 16,
  parameter int unsigned INACC_W = 8
) (
  input logic [OP_W-1:0] a_i,
  input logic [OP_W-1:0] b_i,
  input logic [OP_W:0]   sum_o
);
  localparam int unsigned ACC_W = OP_W - INACC_W;

  logic [OP_W:0]      exact;
  logic [ACC_W:0]     hi_exact;
  logic [INACC_W:0]   lo_exact;
  logic [OP_W:0]      err;

  always_comb begin
    exact    = {1'b0, a_i} + {1'b0, b_i};
    hi_exact = {1'b0, a_i[OP_W-1:INACC_W]} + {1'b0, b_i[OP_W-1:INACC_W]};
    lo_exact = {1'b0, a_i[INACC_W-1:0]} + {1'b0, b_i[INACC_W-1:0]};
    err      = exact - sum_o;
    assert_upper_exact_R1: assert (sum_o[OP_W:INACC_W] == hi_exact)
      else $error("R1 upper field mismatch");
    if ((a_i[INACC_W-1:0] & b_i[INACC_W-1:0]) == '0) begin
      assert_lower_exact_R4: assert (sum_o[INACC_W-1:0] == lo_exact[INACC_W-1:0])
        else $error("R4 lower field not exact");
    end
    assert_no_overshoot_R5: assert (sum_o <= exact)
      else $error("R5 result exceeds exact sum");
    assert_err_bound_R8: assert (err < ((OP_W+1)'(1) << (INACC_W + 1)))
      else $error("R8 error bound exceeded");
  end
endmodule

bind approx_trunc_adder approx_trunc_adder_chk #(.OP_W(OP_W), .INACC_W(INACC_W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sum_o (sum_o)
);

// File: tb/approx_trunc_adder_test.sv
module approx_trunc_adder_test;
  localparam int unsigned OP_W    = 16;
  localparam int unsigned INACC_W = 8;
  localparam int unsigned ACC_W   = OP_W - INACC_W;
  localparam int unsigned LO_N    = 1 << INACC_W;

  typedef struct {
    logic [OP_W-1:0] a;
    logic [OP_W-1:0] b;
    logic [OP_W:0]   exp;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [OP_W-1:0] a, b;
  logic [OP_W:0]   sum;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  item_t q[$];

  always #5 clk = ~clk;

  approx_trunc_adder #(.OP_W(OP_W), .INACC_W(INACC_W)) uut (
    .a_i(a), .b_i(b), .sum_o(sum)
  );

  // Reference: top-down scan of the lower section, plain add of the upper.
  function automatic logic [OP_W:0] ref_sum(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
    logic [OP_W:0] r;
    logic          sat;
    logic [ACC_W:0] hi;
    r   = '0;
    sat = 1'b0;
    for (int i = INACC_W - 1; i >= 0; i--) begin
      if (x[i] && y[i]) sat = 1'b1;
      r[i] = sat ? 1'b1 : (x[i] ^ y[i]);
    end
    hi = {1'b0, x[OP_W-1:INACC_W]} + {1'b0, y[OP_W-1:INACC_W]};
    r[OP_W:INACC_W] = hi;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [OP_W:0] act, input logic [OP_W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y, input logic [OP_W:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    {a, b} = {x, y};
    it.a = x; it.b = y; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: results sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      logic [OP_W:0] ex;
      it = q.pop_front();
      ex = {1'b0, it.a} + {1'b0, it.b};
      check(sum === it.exp, it.tag, sum, it.exp);
      check(sum <= ex, "R5 no overshoot", sum, ex);
      check((ex - sum) < ((OP_W+1)'(1) << (INACC_W + 1)), "R8 error bound", ex - sum, ex);
    end
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    logic [OP_W-1:0] x, y;
    a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1 zero operands give zero
    drive('0, '0, '0, "R1 reset-state zero sum");
    // R6 worked example
    drive(16'd45978, 16'd26899, 17'd72863, "R6 worked example");
    // R4 disjoint lower bits give exact lower sum
    drive(16'h12AA, 16'h3455, 17'h046FF, "R4 exact lower sum");
    // R3 top lower bit double-one saturates whole lower field
    drive(16'h0080, 16'h0080, 17'h000FF, "R3 full saturation");
    // R2 XOR above saturation point: 0x34 & 0x24 -> first double-one at bit5
    drive(16'h0034, 16'h0024, 17'h0003F, "R2 xor above saturation");
    // R7 all-ones lower halves add no carry into upper field
    drive(16'h00FF, 16'h00FF, 17'h000FF, "R7 no carry into upper");
    // R1 upper carry-out
    drive(16'hFF00, 16'h0100, 17'h10000, "R1 upper carry-out");
    // R7 lower bits leave upper field unchanged
    drive(16'hA5FF, 16'h5AFF, 17'h0FFFF, "R7 upper unaffected");
    drive(16'hA500, 16'h5A00, 17'h0FF00, "R7 upper unaffected");
    // R2 R3 exhaustive lower sweep, random upper halves
    for (int i = 0; i < LO_N; i++) begin
      for (int j = 0; j < LO_N; j++) begin
        x = {ACC_W'($urandom), INACC_W'(i)};
        y = {ACC_W'($urandom), INACC_W'(j)};
        drive(x, y, ref_sum(x, y), "R2_R3 sweep vs reference");
      end
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end
endmodule